// File: doc/BRIEF.md
# Page Migration Sequencer

This block moves one physical page of memory from a source frame to a destination frame while the rest of the system keeps running. A single command names the logical page and the two frames. The block then works through a fixed series of handshakes. It asks the translation buffers which one currently maps the page. It asks the caches to flush that page's lines and waits until every writeback those flushes caused has drained. It then copies the page burst by burst. Finally it gives the new mapping to the translation buffer that held the old one.

Every neighbour is modelled as a plain request/acknowledge port. A request stays high, with stable payload, until the neighbour acknowledges it for one cycle. The block chooses no page itself. A placement or eviction policy elsewhere decides what to move and issues the command.

Top module: `pgmig_seq`

## Requirements
- R1: `cmd_ready` is high exactly when the block is idle. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. While a migration is running, `cmd_valid` is ignored: no second lookup starts after the running migration completes.
- R2: After a command is accepted, `lk_req` rises with `lk_lpn` equal to the commanded logical page. The block samples the holder vector `lk_hit` (bit i set means translation buffer i holds the page) in the cycle `lk_ack` is high.
- R3: `fl_req` is raised with `fl_lpn` equal to the commanded page, and only after the lookup was acknowledged. It is held until `fl_ack`.
- R4: After `fl_ack`, no read of the page is issued until `wb_idle` has been observed high.
- R5: The copy moves the page (8192 bytes by default) as 256 bursts of 32 bytes, in ascending order. Burst k reads byte address src_frame*8192 + k*32 and then writes the data it read to dst_frame*8192 + k*32. The write of a burst follows that burst's read acknowledge, and only one request is outstanding at a time.
- R6: Every request (`lk_req`, `fl_req`, `rd_req`, `wr_req`, `tu_req`) stays high, with its address and data stable, until it is acknowledged.
- R7: When at least one buffer reported holding the page, `tu_req` rises after the last write acknowledge. It carries a one-hot `tu_sel`, `tu_lpn` equal to the page and `tu_frame` equal to the destination frame, and is held until `tu_ack`.
- R8: When several bits of `lk_hit` are set, `tu_sel` selects the lowest-numbered one.
- R9: When `lk_hit` is all zero, the flush and the copy still run, and `tu_req` is never raised.
- R10: `done` is high for exactly one cycle: the cycle after the final acknowledge (`tu_ack`, or the last `wr_ack` on a miss). In that cycle `cmd_ready` is already high.
- R11: At most one of the five request outputs is high in any cycle. Out of reset every output is low except `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Migration command present |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_lpn | input | LPN_W | Logical page number to move |
| cmd_src_frame | input | FRAME_W | Source physical frame |
| cmd_dst_frame | input | FRAME_W | Destination physical frame |
| lk_req | output | 1 | Translation holder lookup request |
| lk_lpn | output | LPN_W | Page being looked up |
| lk_ack | input | 1 | Lookup answered |
| lk_hit | input | NUM_TLB | Bit i: buffer i holds the mapping |
| fl_req | output | 1 | Flush request for the page's cache lines |
| fl_lpn | output | LPN_W | Page to flush |
| fl_ack | input | 1 | Flush issued |
| wb_idle | input | 1 | No flush writeback outstanding |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | FRAME_W+PAGE_SHIFT | Burst read byte address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | BURST_BYTES*8 | Read burst data |
| wr_req | output | 1 | Burst write request |
| wr_addr | output | FRAME_W+PAGE_SHIFT | Burst write byte address |
| wr_data | output | BURST_BYTES*8 | Burst write data |
| wr_ack | input | 1 | Write accepted |
| tu_req | output | 1 | Translation update request |
| tu_sel | output | NUM_TLB | One-hot buffer to update |
| tu_lpn | output | LPN_W | Page whose mapping changes |
| tu_frame | output | FRAME_W | New physical frame |
| tu_ack | input | 1 | Update installed |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked by assertions in every cycle:
- request exclusivity and quiet outputs while idle;
- requests holding with stable payload;
- flush only after lookup acknowledge, read start only after a drained writeback or a finished write;
- a one-hot update selector;
- the single-cycle done pulse.

Other behaviour only the bench's scenarios show: the exact address and data of every burst against a reference memory function, the choice among several reported holders, the skipped update on a miss, and a command ignored while busy.

// File: rtl/pgmig_pkg.sv
package pgmig_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_FLUSH,
    ST_DRAIN,
    ST_COPY,
    ST_UPDATE
  } mig_state_e;

  typedef enum logic [1:0] {
    CP_IDLE,
    CP_RD,
    CP_WR
  } cp_phase_e;

endpackage

// File: rtl/pgmig_hit_pick.sv
module pgmig_hit_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] hit,
  output logic [N-1:0] sel,
  output logic         any
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_pick
    assign sel[i]    = hit[i] & ~seen[i];
    assign seen[i+1] = seen[i] | hit[i];
  end

  assign any = seen[N];

endmodule

// File: rtl/pgmig_burst_ctr.sv
module pgmig_burst_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    if (clr)      cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign last = &cnt_q;

endmodule

// File: rtl/pgmig_copy.sv
module pgmig_copy
  import pgmig_pkg::*;
#(
  parameter int FRAME_W     = 20,
  parameter int PAGE_SHIFT  = 13,
  parameter int BURST_SHIFT = 5,
  parameter int DATA_W      = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [FRAME_W-1:0]            src_frame,
  input  logic [FRAME_W-1:0]            dst_frame,
  output logic                          rd_req,
  output logic [FRAME_W+PAGE_SHIFT-1:0] rd_addr,
  input  logic                          rd_ack,
  input  logic [DATA_W-1:0]             rd_data,
  output logic                          wr_req,
  output logic [FRAME_W+PAGE_SHIFT-1:0] wr_addr,
  output logic [DATA_W-1:0]             wr_data,
  input  logic                          wr_ack,
  output logic                          finish
);

  localparam int CNT_W = PAGE_SHIFT - BURST_SHIFT;

  cp_phase_e         phase_q, phase_d;
  logic              load;
  logic              inc;
  logic [CNT_W-1:0]  cnt;
  logic              last;
  logic [DATA_W-1:0] data_q;

  pgmig_burst_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .inc  (inc),
    .cnt  (cnt),
    .last (last)
  );

  always_comb begin
    phase_d = phase_q;
    load    = 1'b0;
    inc     = 1'b0;
    finish  = 1'b0;
    case (phase_q)
      CP_IDLE: if (start) phase_d = CP_RD;
      CP_RD: begin
        if (rd_ack) begin
          load    = 1'b1;
          phase_d = CP_WR;
        end
      end
      CP_WR: begin
        if (wr_ack) begin
          inc = 1'b1;
          if (last) begin
            finish  = 1'b1;
            phase_d = CP_IDLE;
          end else begin
            phase_d = CP_RD;
          end
        end
      end
      default: phase_d = CP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= CP_IDLE;
    else        phase_q <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= rd_data;
  end

  assign rd_req  = (phase_q == CP_RD);
  assign wr_req  = (phase_q == CP_WR);
  assign rd_addr = {src_frame, cnt, {BURST_SHIFT{1'b0}}};
  assign wr_addr = {dst_frame, cnt, {BURST_SHIFT{1'b0}}};
  assign wr_data = data_q;

  // R5: a write only follows an acknowledged read
  a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_req && rd_ack));

  // R6: read held with stable address until acknowledged
  a_r6_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));

  // R6: write held with stable address and data until acknowledged
  a_r6_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));

endmodule

// File: rtl/pgmig_seq.sv
module pgmig_seq
  import pgmig_pkg::*;
#(
  parameter int LPN_W       = 24,
  parameter int FRAME_W     = 20,
  parameter int NUM_TLB     = 4,
  parameter int PAGE_BYTES  = 8192,
  parameter int BURST_BYTES = 32,
  localparam int PAGE_SHIFT  = $clog2(PAGE_BYTES),
  localparam int BURST_SHIFT = $clog2(BURST_BYTES),
  localparam int ADDR_W      = FRAME_W + PAGE_SHIFT,
  localparam int DATA_W      = BURST_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [LPN_W-1:0]   cmd_lpn,
  input  logic [FRAME_W-1:0] cmd_src_frame,
  input  logic [FRAME_W-1:0] cmd_dst_frame,
  output logic               lk_req,
  output logic [LPN_W-1:0]   lk_lpn,
  input  logic               lk_ack,
  input  logic [NUM_TLB-1:0] lk_hit,
  output logic               fl_req,
  output logic [LPN_W-1:0]   fl_lpn,
  input  logic               fl_ack,
  input  logic               wb_idle,
  output logic               rd_req,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic               rd_ack,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               wr_req,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  input  logic               wr_ack,
  output logic               tu_req,
  output logic [NUM_TLB-1:0] tu_sel,
  output logic [LPN_W-1:0]   tu_lpn,
  output logic [FRAME_W-1:0] tu_frame,
  input  logic               tu_ack,
  output logic               done
);

  mig_state_e         state_q, state_d;
  logic [LPN_W-1:0]   lpn_q;
  logic [FRAME_W-1:0] src_q, dst_q;
  logic [NUM_TLB-1:0] sel_q;
  logic               any_q;
  logic [NUM_TLB-1:0] pick_sel;
  logic               pick_any;
  logic               accept;
  logic               cap_hit;
  logic               copy_start;
  logic               copy_finish;
  logic               done_d, done_q;

  pgmig_hit_pick #(.N(NUM_TLB)) u_pick (
    .hit(lk_hit),
    .sel(pick_sel),
    .any(pick_any)
  );

  pgmig_copy #(
    .FRAME_W    (FRAME_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .BURST_SHIFT(BURST_SHIFT),
    .DATA_W     (DATA_W)
  ) u_copy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (copy_start),
    .src_frame(src_q),
    .dst_frame(dst_q),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ack   (wr_ack),
    .finish   (copy_finish)
  );

  always_comb begin
    state_d    = state_q;
    accept     = 1'b0;
    cap_hit    = 1'b0;
    copy_start = 1'b0;
    done_d     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          accept  = 1'b1;
          state_d = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lk_ack) begin
          cap_hit = 1'b1;
          state_d = ST_FLUSH;
        end
      end
      ST_FLUSH: if (fl_ack) state_d = ST_DRAIN;
      ST_DRAIN: begin
        if (wb_idle) begin
          copy_start = 1'b1;
          state_d    = ST_COPY;
        end
      end
      ST_COPY: begin
        if (copy_finish) begin
          if (any_q) begin
            state_d = ST_UPDATE;
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_UPDATE: begin
        if (tu_ack) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lpn_q <= '0;
      src_q <= '0;
      dst_q <= '0;
    end else if (accept) begin
      lpn_q <= cmd_lpn;
      src_q <= cmd_src_frame;
      dst_q <= cmd_dst_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      any_q <= 1'b0;
    end else if (cap_hit) begin
      sel_q <= pick_sel;
      any_q <= pick_any;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign lk_req    = (state_q == ST_LOOKUP);
  assign fl_req    = (state_q == ST_FLUSH);
  assign tu_req    = (state_q == ST_UPDATE);
  assign lk_lpn    = lpn_q;
  assign fl_lpn    = lpn_q;
  assign tu_lpn    = lpn_q;
  assign tu_frame  = dst_q;
  assign tu_sel    = sel_q;
  assign done      = done_q;

  // R1: an idle block drives no request
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !(lk_req || fl_req || rd_req || wr_req || tu_req));

  // R11: requests are mutually exclusive
  a_r11_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_req, fl_req, rd_req, wr_req, tu_req}));

  // R6: lookup held with stable page until acknowledged
  a_r6_lk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req && !lk_ack |=> lk_req && $stable(lk_lpn));

  // R3: flush begins only right after an acknowledged lookup
  a_r3_flush_after_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_req) |-> $past(lk_req && lk_ack));

  // R4: a read starts only after a drained writeback or a finished write
  a_r4_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req) |-> ($past(wb_idle) || $past(wr_req && wr_ack)));

  // R7: update targets exactly one buffer
  a_r7_update_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    tu_req |-> $onehot(tu_sel));

  // R6: update held with stable payload until acknowledged
  a_r6_tu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tu_req && !tu_ack |=> tu_req && $stable(tu_sel) && $stable(tu_frame));

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/pgmig_seq_tb.sv
`timescale 1ns/1ps
module pgmig_seq_tb;

  localparam int LPN_W   = 24;
  localparam int FRAME_W = 20;
  localparam int NT      = 4;
  localparam int ADDR_W  = 33;
  localparam int DATA_W  = 256;
  localparam int BURSTS  = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               cmd_valid = 1'b0, cmd_ready;
  logic [LPN_W-1:0]   cmd_lpn = '0;
  logic [FRAME_W-1:0] cmd_src_frame = '0, cmd_dst_frame = '0;
  logic               lk_req, lk_ack = 1'b0;
  logic [LPN_W-1:0]   lk_lpn, fl_lpn, tu_lpn;
  logic [NT-1:0]      lk_hit = '0, tu_sel;
  logic               fl_req, fl_ack = 1'b0, wb_idle = 1'b1;
  logic               rd_req, rd_ack = 1'b0, wr_req, wr_ack = 1'b0;
  logic [ADDR_W-1:0]  rd_addr, wr_addr;
  logic [DATA_W-1:0]  rd_data = '0, wr_data;
  logic               tu_req, tu_ack = 1'b0, done;
  logic [FRAME_W-1:0] tu_frame;

  pgmig_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_lpn(cmd_lpn),
    .cmd_src_frame(cmd_src_frame), .cmd_dst_frame(cmd_dst_frame),
    .lk_req(lk_req), .lk_lpn(lk_lpn), .lk_ack(lk_ack), .lk_hit(lk_hit),
    .fl_req(fl_req), .fl_lpn(fl_lpn), .fl_ack(fl_ack), .wb_idle(wb_idle),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .tu_req(tu_req), .tu_sel(tu_sel), .tu_lpn(tu_lpn), .tu_frame(tu_frame),
    .tu_ack(tu_ack), .done(done)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mem_fn(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < DATA_W/32; i++)
      d[i*32 +: 32] = (a[31:0] * 32'h9E3779B1) + 32'(i) + {31'b0, a[32]};
    return d;
  endfunction

  function automatic logic [NT-1:0] low_pick(input logic [NT-1:0] h);
    for (int i = 0; i < NT; i++) if (h[i]) return NT'(1) << i;
    return '0;
  endfunction

  // expectations for the running migration
  logic [LPN_W-1:0]   exp_lpn;
  logic [FRAME_W-1:0] exp_src, exp_dst;
  logic [NT-1:0]      exp_hit;
  int  beat;
  bit  lk_done, drained, tu_seen, rd_first_chk, lk_after;
  int  lk_dly, fl_dly, rd_dly, wr_dly, tu_dly, drain_cnt;

  // neighbour models: acks driven at the falling edge, one cycle wide
  initial begin
    lk_dly = 0; fl_dly = 0; rd_dly = 0; wr_dly = 0; tu_dly = 0; drain_cnt = 0;
    forever begin
      @(negedge clk);
      if (lk_req) lk_after = 1'b1;
      if (drain_cnt > 0) begin
        drain_cnt--;
        if (drain_cnt == 0) begin wb_idle = 1'b1; drained = 1'b1; end
      end
      if (lk_ack) lk_ack = 1'b0;
      else if (lk_req) begin
        if (lk_dly == 0) begin
          chk(lk_lpn == exp_lpn, "R2 lookup page", DATA_W'(lk_lpn), DATA_W'(exp_lpn));
          lk_hit = exp_hit; lk_ack = 1'b1; lk_done = 1'b1; lk_dly = $urandom % 4;
        end else lk_dly--;
      end
      if (fl_ack) fl_ack = 1'b0;
      else if (fl_req) begin
        if (fl_dly == 0) begin
          chk(lk_done, "R3 flush after lookup", DATA_W'(lk_done), 1);
          chk(fl_lpn == exp_lpn, "R3 flush page", DATA_W'(fl_lpn), DATA_W'(exp_lpn));
          fl_ack = 1'b1; wb_idle = 1'b0; drain_cnt = 1 + $urandom % 6;
          fl_dly = $urandom % 4;
        end else fl_dly--;
      end
      if (rd_ack) rd_ack = 1'b0;
      else if (rd_req) begin
        if (!rd_first_chk) begin
          rd_first_chk = 1'b1;
          chk(drained, "R4 read after drain", DATA_W'(drained), 1);
        end
        if (rd_dly == 0) begin
          chk(rd_addr == {exp_src, 8'(beat), 5'b0}, "R5 read address",
              DATA_W'(rd_addr), DATA_W'({exp_src, 8'(beat), 5'b0}));
          rd_data = mem_fn(rd_addr); rd_ack = 1'b1; rd_dly = $urandom % 4;
        end else rd_dly--;
      end
      if (wr_ack) wr_ack = 1'b0;
      else if (wr_req) begin
        if (wr_dly == 0) begin
          chk(wr_addr == {exp_dst, 8'(beat), 5'b0}, "R5 write address",
              DATA_W'(wr_addr), DATA_W'({exp_dst, 8'(beat), 5'b0}));
          chk(wr_data == mem_fn({exp_src, 8'(beat), 5'b0}), "R5 write data",
              wr_data, mem_fn({exp_src, 8'(beat), 5'b0}));
          wr_ack = 1'b1; beat++; wr_dly = $urandom % 4;
        end else wr_dly--;
      end
      if (tu_ack) tu_ack = 1'b0;
      else if (tu_req) begin
        if (tu_dly == 0) begin
          chk(exp_hit != '0, "R9 no update on miss", DATA_W'(tu_req), 0);
          chk(tu_sel == low_pick(exp_hit), "R8 lowest holder selected",
              DATA_W'(tu_sel), DATA_W'(low_pick(exp_hit)));
          chk(tu_lpn == exp_lpn && tu_frame == exp_dst, "R7 update payload",
              DATA_W'({tu_lpn, tu_frame}), DATA_W'({exp_lpn, exp_dst}));
          chk(beat == BURSTS, "R7 update after last write", DATA_W'(beat), BURSTS);
          tu_ack = 1'b1; tu_seen = 1'b1; tu_dly = $urandom % 4;
        end else tu_dly--;
      end
    end
  end

  task automatic migrate(input logic [LPN_W-1:0] lpn, input logic [FRAME_W-1:0] src,
                         input logic [FRAME_W-1:0] dst, input logic [NT-1:0] hit,
                         input bit poke);
    int cyc;
    exp_lpn = lpn; exp_src = src; exp_dst = dst; exp_hit = hit;
    beat = 0; lk_done = 0; drained = 0; tu_seen = 0; rd_first_chk = 0;
    @(negedge clk);
    chk(cmd_ready, "R1 ready when idle", DATA_W'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_lpn = lpn; cmd_src_frame = src; cmd_dst_frame = dst;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1 busy after accept", DATA_W'(cmd_ready), 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      if (poke && cyc == 30) begin
        cmd_valid = 1'b1; cmd_lpn = ~lpn; cmd_src_frame = dst; cmd_dst_frame = src;
      end else cmd_valid = 1'b0;
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    chk(done, "R10 done seen", DATA_W'(done), 1);
    chk(cmd_ready, "R10 idle with done", DATA_W'(cmd_ready), 1);
    chk(beat == BURSTS, "R5 burst count", DATA_W'(beat), BURSTS);
    chk(tu_seen == (hit != '0), "R9 update only on hit", DATA_W'(tu_seen), DATA_W'(hit != '0));
    lk_after = 1'b0;
    @(negedge clk);
    chk(!done, "R10 done one cycle", DATA_W'(done), 0);
    if (poke) begin
      repeat (6) @(negedge clk);
      chk(!lk_after && cmd_ready, "R1 busy command ignored", DATA_W'(lk_after), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk({cmd_ready, lk_req, fl_req, rd_req, wr_req, tu_req, done} == 7'b1000000,
        "R11 reset state", DATA_W'({cmd_ready, lk_req, fl_req, rd_req, wr_req, tu_req, done}),
        DATA_W'(7'b1000000));
    rst_n = 1'b1;
    migrate(24'h00_0042, 20'h00010, 20'hF0020, 4'b0001, 1'b0);
    migrate(24'h12_3456, 20'h00003, 20'h80004, 4'b0000, 1'b0);   // miss
    migrate(24'hAB_CDEF, 20'hFFFFF, 20'h00000, 4'b1000, 1'b0);   // top frame
    migrate(24'h00_0777, 20'h0ABCD, 20'h1234F, 4'b1010, 1'b0);   // multi-hit
    migrate(24'h55_AA55, 20'h00100, 20'h00200, 4'b0100, 1'b1);   // busy poke
    for (int n = 0; n < 11; n++)
      migrate(LPN_W'($urandom), FRAME_W'($urandom), FRAME_W'($urandom),
              NT'($urandom % 16), n[0]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule